// File: doc/BRIEF.md
# Interrupt Control and Status Word

A single 32-bit memory-mapped word sitting beside a small exception controller. Software uses it to make two system exceptions pending, or to withdraw their pending state: a deferred-service request and a periodic-timer request. Each has its own write-one-to-set and write-one-to-clear bit. A zero written to any of these bits does nothing. The pending state of the two exceptions is held here and is also driven out to the exception sequencer.

The same word gives software a read-only view of the controller's state. It shows whether any external interrupt is pending and which pending, enabled exception would win arbitration next. It also shows whether the core would drop back to base level on return from the current handler, and the number of the exception now active. The arbiter applies the base-priority threshold and the fault-mask. No input for the primary interrupt mask exists, so that mask cannot affect the reported vector. Register selection, the address decode and the exception entry sequencing are handled outside the block.

Top module: `exc_ctrl_status_reg`

## Requirements
- R1: After reset both held pending bits are 0. With all inputs at 0 the word reads 32'h0000_0800.
- R2: A write with bit 28 set makes the deferred-service exception pending, and this shows on bit 28 from the next cycle on. A write with bit 28 at 0 leaves that state as it was.
- R3: A write with bit 27 set clears the deferred-service pending state. Bit 27 always reads 0.
- R4: Bits 26 and 25 act on the timer exception in the same way as bits 28 and 27. Bit 26 reads its pending state and bit 25 always reads 0.
- R5: A single write that sets both the set bit and the clear bit of one exception leaves that exception not pending.
- R6: The held state does not change in a cycle where reg_sel_i or reg_wr_i is low.
- R7: Bit 22 reads 1 exactly when exc_pend_i has a bit set at exception number 16 or above, whatever that exception's enable. Numbers below 16 do not count.
- R8: Bits 18:12 give the number of the pending, enabled exception with the lowest signed priority value, the lower number winning a tie. The field reads 0 when no exception qualifies, and exception 0 never qualifies. Exceptions 14 and 15 take their pending state from the held deferred-service and timer bits.
- R9: When base_pri_i is nonzero, an exception whose priority is not strictly below base_pri_i is left out of the bits 18:12 result.
- R10: When fault_mask_i is 1, only exceptions with a negative priority are considered for bits 18:12.
- R11: Bit 11 reads 1 when at most one bit of exc_active_i is set, and 0 otherwise.
- R12: Bits 8:0 echo act_num_i. Bits 31:29, 24:19 other than 22, and 10:9 read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_sel_i | input | 1 | Word selected by the bus decode |
| reg_wr_i | input | 1 | Write strobe |
| reg_wdata_i | input | 32 | Write data |
| reg_rdata_o | output | 32 | Read data, combinational |
| act_num_i | input | 9 | Number of the exception now active, 0 in thread mode |
| exc_active_i | input | NUM_EXC | Active flag for each exception |
| exc_pend_i | input | NUM_EXC | Pending flag for each exception (bits 14 and 15 are replaced) |
| exc_en_i | input | NUM_EXC | Enable for each exception |
| exc_prio_i | input | NUM_EXC*(PRIO_W+1) | Signed priority for each exception, packed by exception number |
| base_pri_i | input | PRIO_W | Base-priority threshold, 0 means off |
| fault_mask_i | input | 1 | Fault-mask, allows only negative priorities |
| defer_pend_o | output | 1 | Deferred-service exception pending |
| timer_pend_o | output | 1 | Timer exception pending |

## Verification
The hardest case to reach from the ports is the pending-vector result when several filters act at once. A candidate has to be pending and enabled, must sit below a nonzero threshold, and may be cut by the fault-mask, while held system bits and signed ties also take part. Random stimulus makes pending bits sparse and gives negative priorities only sometimes, so that both the threshold and the fault-mask change the winner in a good share of cycles. Directed cases then pin down ties, a threshold equal to a priority, and a winner coming from the held bits.

// File: rtl/icsr_pkg.sv
package icsr_pkg;
  localparam int WORD_W      = 32;
  localparam int DEFER_SET_B = 28;
  localparam int DEFER_CLR_B = 27;
  localparam int TIMER_SET_B = 26;
  localparam int TIMER_CLR_B = 25;
  localparam int EXT_PEND_B  = 22;
  localparam int VPEND_LSB   = 12;
  localparam int VPEND_W     = 7;
  localparam int BASE_LVL_B  = 11;
  localparam int ACT_W       = 9;

  typedef struct packed {
    logic set;
    logic clr;
  } pend_cmd_t;
endpackage

// File: rtl/icsr_sys_pend.sv
module icsr_sys_pend
  import icsr_pkg::*;
#(
  parameter int N_SYS = 2
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 wr_en_i,
  input  pend_cmd_t [N_SYS-1:0] cmd_i,
  output logic [N_SYS-1:0]     pend_o
);
  for (genvar g = 0; g < N_SYS; g++) begin : g_sys
    logic pend_q;
    logic pend_d;

    always_comb begin
      pend_d = pend_q;
      if (cmd_i[g].set) pend_d = 1'b1;
      if (cmd_i[g].clr) pend_d = 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        pend_q <= 1'b0;
      end else if (wr_en_i) begin
        pend_q <= pend_d;
      end
    end

    assign pend_o[g] = pend_q;
  end
endmodule

// File: rtl/icsr_arbiter.sv
module icsr_arbiter
  import icsr_pkg::*;
#(
  parameter int NUM_EXC = 48,
  parameter int PRIO_W  = 4
) (
  input  logic [NUM_EXC-1:0]          pend_i,
  input  logic [NUM_EXC-1:0]          en_i,
  input  logic [NUM_EXC*(PRIO_W+1)-1:0] prio_i,
  input  logic [PRIO_W-1:0]           base_pri_i,
  input  logic                        fault_mask_i,
  output logic [VPEND_W-1:0]          vect_o
);
  localparam int PW = PRIO_W + 1;

  logic signed [PW-1:0] base_s;
  assign base_s = $signed({1'b0, base_pri_i});

  always_comb begin
    logic                 found;
    logic                 elig;
    logic signed [PW-1:0] p;
    logic signed [PW-1:0] best_p;
    found  = 1'b0;
    elig   = 1'b0;
    p      = '0;
    best_p = '0;
    vect_o = '0;
    for (int i = 0; i < NUM_EXC; i++) begin
      p    = $signed(prio_i[i*PW +: PW]);
      elig = pend_i[i] && en_i[i] && (i != 0);
      if ((base_pri_i != '0) && !(p < base_s)) elig = 1'b0;
      if (fault_mask_i && !(p < 0)) elig = 1'b0;
      if (elig && (!found || (p < best_p))) begin
        found  = 1'b1;
        best_p = p;
        vect_o = VPEND_W'(i);
      end
    end
  end
endmodule

// File: rtl/icsr_status.sv
module icsr_status #(
  parameter int NUM_EXC  = 48,
  parameter int EXT_BASE = 16
) (
  input  logic [NUM_EXC-EXT_BASE-1:0] ext_pend_i,
  input  logic [NUM_EXC-1:0]          active_i,
  output logic                        ext_any_o,
  output logic                        base_lvl_o
);
  assign ext_any_o  = |ext_pend_i;
  assign base_lvl_o = ((active_i & (active_i - 1'b1)) == '0);
endmodule

// File: rtl/exc_ctrl_status_reg.sv
module exc_ctrl_status_reg
  import icsr_pkg::*;
#(
  parameter int NUM_EXC   = 48,
  parameter int PRIO_W    = 4,
  parameter int EXT_BASE  = 16,
  parameter int DEFER_NUM = 14,
  parameter int TIMER_NUM = 15
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          reg_sel_i,
  input  logic                          reg_wr_i,
  input  logic [31:0]                   reg_wdata_i,
  output logic [31:0]                   reg_rdata_o,
  input  logic [8:0]                    act_num_i,
  input  logic [NUM_EXC-1:0]            exc_active_i,
  input  logic [NUM_EXC-1:0]            exc_pend_i,
  input  logic [NUM_EXC-1:0]            exc_en_i,
  input  logic [NUM_EXC*(PRIO_W+1)-1:0] exc_prio_i,
  input  logic [PRIO_W-1:0]             base_pri_i,
  input  logic                          fault_mask_i,
  output logic                          defer_pend_o,
  output logic                          timer_pend_o
);
  localparam int N_SYS = 2;

  logic                   wr_en;
  pend_cmd_t [N_SYS-1:0]  cmd;
  logic [N_SYS-1:0]       sys_pend;
  logic [NUM_EXC-1:0]     pend_eff;
  logic [VPEND_W-1:0]     vect;
  logic                   ext_any;
  logic                   base_lvl;
  logic                   unused_wdata;

  assign wr_en      = reg_sel_i & reg_wr_i;
  assign cmd[0].set = reg_wdata_i[DEFER_SET_B];
  assign cmd[0].clr = reg_wdata_i[DEFER_CLR_B];
  assign cmd[1].set = reg_wdata_i[TIMER_SET_B];
  assign cmd[1].clr = reg_wdata_i[TIMER_CLR_B];
  assign unused_wdata = ^{reg_wdata_i[31:29], reg_wdata_i[24:0]};

  icsr_sys_pend #(.N_SYS(N_SYS)) u_sys_pend (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en_i (wr_en),
    .cmd_i   (cmd),
    .pend_o  (sys_pend)
  );

  always_comb begin
    pend_eff            = exc_pend_i;
    pend_eff[DEFER_NUM] = sys_pend[0];
    pend_eff[TIMER_NUM] = sys_pend[1];
  end

  icsr_arbiter #(.NUM_EXC(NUM_EXC), .PRIO_W(PRIO_W)) u_arb (
    .pend_i       (pend_eff),
    .en_i         (exc_en_i),
    .prio_i       (exc_prio_i),
    .base_pri_i   (base_pri_i),
    .fault_mask_i (fault_mask_i),
    .vect_o       (vect)
  );

  icsr_status #(.NUM_EXC(NUM_EXC), .EXT_BASE(EXT_BASE)) u_status (
    .ext_pend_i (exc_pend_i[NUM_EXC-1:EXT_BASE]),
    .active_i   (exc_active_i),
    .ext_any_o  (ext_any),
    .base_lvl_o (base_lvl)
  );

  always_comb begin
    reg_rdata_o                            = '0;
    reg_rdata_o[DEFER_SET_B]               = sys_pend[0];
    reg_rdata_o[TIMER_SET_B]               = sys_pend[1];
    reg_rdata_o[EXT_PEND_B]                = ext_any;
    reg_rdata_o[VPEND_LSB +: VPEND_W]      = vect;
    reg_rdata_o[BASE_LVL_B]                = base_lvl;
    reg_rdata_o[ACT_W-1:0]                 = act_num_i;
  end

  assign defer_pend_o = sys_pend[0];
  assign timer_pend_o = sys_pend[1];
endmodule

// File: rtl/exc_ctrl_status_chk.sv
module exc_ctrl_status_chk #(
  parameter int NUM_EXC = 48
) (
  input logic               clk,
  input logic               rst_n,
  input logic               reg_sel_i,
  input logic               reg_wr_i,
  input logic [31:0]        reg_wdata_i,
  input logic [31:0]        reg_rdata_o,
  input logic [NUM_EXC-1:0] exc_active_i,
  input logic [NUM_EXC-1:0] exc_en_i,
  input logic               defer_pend_o,
  input logic               timer_pend_o
);
  logic wr;
  assign wr = reg_sel_i && reg_wr_i;

  // R2
  defer_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && reg_wdata_i[28] && !reg_wdata_i[27]) |=> defer_pend_o);

  // R3
  defer_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && reg_wdata_i[27]) |=> !defer_pend_o);

  // R4
  timer_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && reg_wdata_i[26] && !reg_wdata_i[25]) |=> timer_pend_o);

  // R5
  timer_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && reg_wdata_i[25]) |=> !timer_pend_o);

  // R6
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !wr |=> ($stable(defer_pend_o) && $stable(timer_pend_o)));

  // R11
  base_lvl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    reg_rdata_o[11] == ($countones(exc_active_i) <= 1));

  // R12
  resv_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_rdata_o[31:29] == 3'b0) && (reg_rdata_o[27] == 1'b0) &&
    (reg_rdata_o[25:23] == 3'b0) && (reg_rdata_o[21:19] == 3'b0) &&
    (reg_rdata_o[10:9] == 2'b0));

  // R8
  vect_en_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_rdata_o[18:12] != 7'd0) |-> exc_en_i[reg_rdata_o[18:12]]);
endmodule

bind exc_ctrl_status_reg exc_ctrl_status_chk #(.NUM_EXC(NUM_EXC)) chk_i (
  .clk          (clk),
  .rst_n        (rst_n),
  .reg_sel_i    (reg_sel_i),
  .reg_wr_i     (reg_wr_i),
  .reg_wdata_i  (reg_wdata_i),
  .reg_rdata_o  (reg_rdata_o),
  .exc_active_i (exc_active_i),
  .exc_en_i     (exc_en_i),
  .defer_pend_o (defer_pend_o),
  .timer_pend_o (timer_pend_o)
);

// File: tb/exc_ctrl_status_reg_tb_top.sv
module exc_ctrl_status_reg_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int N  = 48;
  localparam int PW = 5;

  logic           clk = 1'b0;
  logic           rst_n;
  logic           sel, wr;
  logic [31:0]    wdata, rdata;
  logic [8:0]     act_num;
  logic [N-1:0]   active, pend, en;
  logic [N*PW-1:0] prio;
  logic [3:0]     base;
  logic           fm;
  logic           dpo, tpo;

  int nchk = 0;
  int nerr = 0;
  logic def_m, tmr_m;

  always #(CLK_PERIOD/2) clk = ~clk;

  exc_ctrl_status_reg dut_i (
    .clk(clk), .rst_n(rst_n), .reg_sel_i(sel), .reg_wr_i(wr),
    .reg_wdata_i(wdata), .reg_rdata_o(rdata), .act_num_i(act_num),
    .exc_active_i(active), .exc_pend_i(pend), .exc_en_i(en),
    .exc_prio_i(prio), .base_pri_i(base), .fault_mask_i(fm),
    .defer_pend_o(dpo), .timer_pend_o(tpo)
  );

  task automatic chk(string req, logic [31:0] a, logic [31:0] e);
    nchk++;
    if (a !== e) begin
      nerr++;
      $display("FAIL %s: actual %h expected %h", req, a, e);
    end
  endtask

  task automatic set_prio(int i, int v);
    prio[i*PW +: PW] = v[PW-1:0];
  endtask

  function automatic logic [6:0] exp_vect();
    logic found = 1'b0;
    logic [6:0] best = '0;
    int bp = 0;
    for (int i = 1; i < N; i++) begin
      int p = $signed(prio[i*PW +: PW]);
      logic pe = (i == 14) ? def_m : (i == 15) ? tmr_m : pend[i];
      logic ok = pe && en[i];
      if (base != 0 && p >= int'(base)) ok = 1'b0;
      if (fm && p >= 0) ok = 1'b0;
      if (ok && (!found || p < bp)) begin
        found = 1'b1; bp = p; best = 7'(i);
      end
    end
    return best;
  endfunction

  function automatic logic [31:0] exp_word();
    logic [31:0] w = '0;
    w[28] = def_m;
    w[26] = tmr_m;
    w[22] = |pend[N-1:16];
    w[18:12] = exp_vect();
    w[11] = ($countones(active) <= 1);
    w[8:0] = act_num;
    return w;
  endfunction

  task automatic bus_wr(logic s, logic w, logic [31:0] d);
    @(negedge clk);
    sel = s; wr = w; wdata = d;
    @(negedge clk);
    sel = 1'b0; wr = 1'b0; wdata = '0;
    if (s && w) begin
      if (d[28]) def_m = 1'b1;
      if (d[27]) def_m = 1'b0;
      if (d[26]) tmr_m = 1'b1;
      if (d[25]) tmr_m = 1'b0;
    end
    #1;
  endtask

  task automatic clear_inputs();
    pend = '0; en = '0; prio = '0; base = '0; fm = 1'b0;
    active = '0; act_num = '0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    nerr++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    rst_n = 1'b0; sel = 1'b0; wr = 1'b0; wdata = '0;
    def_m = 1'b0; tmr_m = 1'b0;
    clear_inputs();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;
    // R1
    chk("R1", rdata, 32'h0000_0800);
    chk("R1 pend outputs", {dpo, tpo}, 0);

    // R2 set then a write of zero
    bus_wr(1, 1, 32'h1000_0000);
    chk("R2", rdata[28], 1);
    bus_wr(1, 1, 32'h0000_0000);
    chk("R2 zero write", rdata[28], 1);
    // R3
    bus_wr(1, 1, 32'h0800_0000);
    chk("R3", {rdata[28], rdata[27]}, 0);
    // R4
    bus_wr(1, 1, 32'h0400_0000);
    chk("R4 set", {rdata[26], rdata[25], tpo}, 3'b101);
    bus_wr(1, 1, 32'h0200_0000);
    chk("R4 clr", {rdata[26], rdata[25], tpo}, 0);
    // R5
    bus_wr(1, 1, 32'h1800_0000);
    chk("R5 defer", rdata[28], 0);
    bus_wr(1, 1, 32'h0600_0000);
    chk("R5 timer", rdata[26], 0);
    // R6
    bus_wr(1, 0, 32'h1400_0000);
    chk("R6 no wr", {rdata[28], rdata[26]}, 0);
    bus_wr(0, 1, 32'h1400_0000);
    chk("R6 no sel", {rdata[28], rdata[26]}, 0);
    bus_wr(1, 1, 32'h1400_0000);
    bus_wr(0, 1, 32'h0A00_0000);
    chk("R6 clear ignored", {rdata[28], rdata[26]}, 2'b11);
    bus_wr(1, 1, 32'h0A00_0000);

    // R7
    pend[5] = 1'b1; #1;
    chk("R7 low number", rdata[22], 0);
    pend[16] = 1'b1; #1;
    chk("R7 external", rdata[22], 1);
    clear_inputs();

    // R8 tie and order
    pend[20] = 1; pend[21] = 1; en[20] = 1; en[21] = 1;
    set_prio(20, 3); set_prio(21, 3); #1;
    chk("R8 tie", rdata[18:12], 20);
    set_prio(21, 2); #1;
    chk("R8 lower value", rdata[18:12], 21);
    en[21] = 0; en[20] = 0; #1;
    chk("R8 none enabled", rdata[18:12], 0);
    clear_inputs();
    // R8 held bit feeds exception 14
    en[14] = 1; set_prio(14, 4);
    bus_wr(1, 1, 32'h1000_0000);
    chk("R8 held defer", rdata[18:12], 14);
    bus_wr(1, 1, 32'h0800_0000);
    chk("R8 held defer cleared", rdata[18:12], 0);
    clear_inputs();

    // R9
    pend[20] = 1; en[20] = 1; set_prio(20, 5); base = 4'd5; #1;
    chk("R9 equal excluded", rdata[18:12], 0);
    base = 4'd6; #1;
    chk("R9 below included", rdata[18:12], 20);
    // R10
    base = 4'd0; fm = 1'b1; #1;
    chk("R10 nonneg excluded", rdata[18:12], 0);
    pend[3] = 1; en[3] = 1; set_prio(3, -1); #1;
    chk("R10 negative kept", rdata[18:12], 3);
    clear_inputs();

    // R11
    active[3] = 1; active[20] = 1; #1;
    chk("R11 nested", rdata[11], 0);
    active[3] = 0; #1;
    chk("R11 single", rdata[11], 1);
    // R12
    act_num = 9'h1A5; #1;
    chk("R12 active num", rdata[8:0], 9'h1A5);
    clear_inputs();

    // random mix
    for (int it = 0; it < 400; it++) begin
      @(negedge clk);
      pend   = {$urandom, $urandom} & {$urandom, $urandom} & {$urandom, $urandom};
      en     = {$urandom, $urandom};
      active = ($urandom_range(0, 1) != 0) ? N'(1) << $urandom_range(0, N-1)
                                          : {$urandom, $urandom} & {$urandom, $urandom} & {$urandom, $urandom};
      act_num = 9'($urandom);
      for (int i = 0; i < N; i++) set_prio(i, int'($urandom_range(0, 18)) - 3);
      base = ($urandom_range(0, 1) != 0) ? 4'd0 : 4'($urandom);
      fm   = ($urandom_range(0, 7) == 0);
      bus_wr($urandom_range(0, 3) != 0, $urandom_range(0, 3) != 0,
             32'($urandom) & 32'h1E00_0000);
      chk("R2 R4 held bits", {rdata[28], rdata[26]}, {def_m, tmr_m});
      chk("R7 ext pending", rdata[22], (|pend[N-1:16]));
      chk("R8 R9 R10 vector", rdata[18:12], exp_vect());
      chk("R11 base level", rdata[11], ($countones(active) <= 1));
      chk("R12 whole word", rdata, exp_word());
    end

    $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
    $finish;
  end
endmodule